// File: doc/BRIEF.md
# SPD Timing Decoder

This block turns the memory module's presence-detect image into the delay counts that a DDR3 memory controller needs. The image comes in on a stream, one byte per clock, as an address and data pair. The block keeps only the bytes it needs and checks the two key bytes. It rebuilds the timing fields that are split across bytes and nibbles. It then converts each minimum time into whole clock cycles at the module's fastest clock. Only integer arithmetic is used, and every count is rounded up.

The CAS latency cannot be copied from a byte. The block searches the supported-latency bitmask for the smallest latency that covers the minimum CAS access time. When the image finishes, the block raises exactly one of two flags: a valid flag with a full set of counts, or an error flag. The result then stays frozen until reset. Transport of the image over the serial bus and checking of its checksum happen outside the block.

Top module: `spd_timing_decoder`

## Requirements
- R1: While reset is low, and after it is released, `cfg_valid`, `cfg_err` and every count output are zero until a result is produced.
- R2: A byte is stored only in a cycle where `in_valid` is high and `in_addr` is below 30. The block reads these addresses: 2 (device key), 3 (module key), 10 and 11 (timebase dividend and divisor), 12 (minimum tCK), 14 and 15 (latency mask, low and high byte), 16 (tAA), 17 (tWR), 18 (tRCD), 19 (tRRD), 20 (tRP), 21 (upper nibbles), 22 (tRAS low), 23 (tRC low), 24 and 25 (tRFC low and high), 26 (tWTR), 27 (tRTP), 28 (tFAW upper nibble) and 29 (tFAW low). A cycle with `in_valid` low has no effect.
- R3: Each count output equals ceil(T / tCK). T and tCK are both in timebase units and tCK is byte 12. For example, tRFC = 0x0370 at tCK = 0x0A gives 88.
- R4: tRAS is {byte21[3:0], byte22} and tRC is {byte21[7:4], byte23}. tFAW is {byte28[3:0], byte29}, so bits 7:4 of byte 28 have no effect. tRFC is {byte25, byte24}.
- R5: In the 16-bit mask {byte15, byte14}, bit n means CAS latency n+4 is supported. `cas_lat` is the smallest supported latency that is at least ceil(tAA / tCK). For example, mask 0x00BC with tAA 0x69 and tCK 0x0A gives 11.
- R6: If byte 2 is not 0x0B or byte 3 is not 0x02, the result is an error.
- R7: If no supported latency reaches ceil(tAA / tCK), the result is an error. On any error, `cfg_valid` stays low and all counts stay zero.
- R8: A zero value in byte 10, byte 11 or byte 12 gives an error.
- R9: The result (`cfg_valid` or `cfg_err`) appears on the clock edge after the edge that accepts byte 29.
- R10: Once a result is present, further input is ignored. The flags and counts hold until reset.
- R11: `cfg_valid` and `cfg_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Image byte present this cycle |
| in_addr | input | 8 | Byte offset within the image |
| in_data | input | 8 | Image byte value |
| cfg_valid | output | 1 | Counts are valid |
| cfg_err | output | 1 | Image rejected |
| cas_lat | output | CYC_W | Chosen CAS latency in cycles |
| t_rcd | output | CYC_W | Activate to column command, cycles |
| t_rp | output | CYC_W | Precharge time, cycles |
| t_ras | output | CYC_W | Activate to precharge, cycles |
| t_rc | output | CYC_W | Activate to activate, same bank, cycles |
| t_rfc | output | CYC_W | Refresh recovery, cycles |
| t_rrd | output | CYC_W | Activate to activate, other bank, cycles |
| t_wtr | output | CYC_W | Write to read turnaround, cycles |
| t_rtp | output | CYC_W | Read to precharge, cycles |
| t_faw | output | CYC_W | Four-activate window, cycles |
| t_wr | output | CYC_W | Write recovery, cycles |

## Verification
The bench uses the default CYC_W of 16. Every count, including a full 16-bit tRFC divided by a one-unit clock, then fits without truncation, so every result is compared exactly. The bench streams images for 1.25 ns and 1.875 ns modules. It also covers:
- latencies that come only from the high mask byte;
- a tAA that is an exact multiple of tCK;
- garbage in the unused nibble of byte 28;
- each error cause;
- traffic arriving after a result has been produced.

// File: rtl/spd_timing_decoder.sv
module spd_timing_decoder #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_addr,
  input  logic [7:0]       in_data,
  output logic             cfg_valid,
  output logic             cfg_err,
  output logic [CYC_W-1:0] cas_lat,
  output logic [CYC_W-1:0] t_rcd,
  output logic [CYC_W-1:0] t_rp,
  output logic [CYC_W-1:0] t_ras,
  output logic [CYC_W-1:0] t_rc,
  output logic [CYC_W-1:0] t_rfc,
  output logic [CYC_W-1:0] t_rrd,
  output logic [CYC_W-1:0] t_wtr,
  output logic [CYC_W-1:0] t_rtp,
  output logic [CYC_W-1:0] t_faw,
  output logic [CYC_W-1:0] t_wr
);

  localparam int NBYTES = 30;
  localparam int IW     = $clog2(NBYTES);

  logic [7:0]  img_q [NBYTES];
  logic        pend_q, done_q;
  logic        cl_ok;
  logic [4:0]  cl_pick;
  logic [16:0] aa_cyc;
  logic        bad;

  wire         accept = in_valid && !pend_q && !done_q;
  wire  [7:0]  tck    = img_q[12];
  wire  [15:0] mask   = {img_q[15], img_q[14]};

  function automatic logic [16:0] cdiv(input logic [15:0] num, input logic [7:0] den);
    if (den == 8'd0) return 17'd0;
    return ({1'b0, num} + {9'd0, den} - 17'd1) / {9'd0, den};
  endfunction

  assign aa_cyc = cdiv({8'd0, img_q[16]}, tck);

  always_comb begin
    cl_ok   = 1'b0;
    cl_pick = '0;
    for (int n = 15; n >= 0; n--) begin
      if (mask[n] && (17'(n) + 17'd4 >= aa_cyc)) begin
        cl_ok   = 1'b1;
        cl_pick = 5'(n + 4);
      end
    end
  end

  assign bad = (img_q[2] != 8'h0B) || (img_q[3] != 8'h02) ||
               (img_q[10] == 8'd0) || (img_q[11] == 8'd0) ||
               (tck == 8'd0) || !cl_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) img_q[i] <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
      cas_lat   <= '0;
      t_rcd     <= '0;
      t_rp      <= '0;
      t_ras     <= '0;
      t_rc      <= '0;
      t_rfc     <= '0;
      t_rrd     <= '0;
      t_wtr     <= '0;
      t_rtp     <= '0;
      t_faw     <= '0;
      t_wr      <= '0;
    end else begin
      if (accept && in_addr < 8'(NBYTES))
        img_q[in_addr[IW-1:0]] <= in_data;
      pend_q <= accept && (in_addr == 8'(NBYTES - 1));
      if (pend_q) begin
        done_q <= 1'b1;
        if (bad) begin
          cfg_err <= 1'b1;
        end else begin
          cfg_valid <= 1'b1;
          cas_lat   <= CYC_W'(cl_pick);
          t_rcd     <= CYC_W'(cdiv({8'd0, img_q[18]}, tck));
          t_rp      <= CYC_W'(cdiv({8'd0, img_q[20]}, tck));
          t_ras     <= CYC_W'(cdiv({4'd0, img_q[21][3:0], img_q[22]}, tck));
          t_rc      <= CYC_W'(cdiv({4'd0, img_q[21][7:4], img_q[23]}, tck));
          t_rfc     <= CYC_W'(cdiv({img_q[25], img_q[24]}, tck));
          t_rrd     <= CYC_W'(cdiv({8'd0, img_q[19]}, tck));
          t_wtr     <= CYC_W'(cdiv({8'd0, img_q[26]}, tck));
          t_rtp     <= CYC_W'(cdiv({8'd0, img_q[27]}, tck));
          t_faw     <= CYC_W'(cdiv({4'd0, img_q[28][3:0], img_q[29]}, tck));
          t_wr      <= CYC_W'(cdiv({8'd0, img_q[17]}, tck));
        end
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_err)); // R11
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid && $stable(cas_lat) && $stable(t_rfc) && $stable(t_faw)); // R10
  AST_HOLD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err && !cfg_valid && $stable(t_rc)); // R10
  AST_FINISH_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid || cfg_err) |-> $past(in_valid && in_addr == 8'd29, 2)); // R9
  AST_CL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cas_lat >= CYC_W'(4) && cas_lat <= CYC_W'(19))); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cas_lat == '0 && t_rcd == '0 && t_rfc == '0)); // R7

endmodule

// File: tb/test_spd_timing_decoder.sv
module test_spd_timing_decoder;
  localparam int CLK_PER = 10;
  localparam int CYC_W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic cfg_valid, cfg_err;
  logic [CYC_W-1:0] cas_lat, t_rcd, t_rp, t_ras, t_rc, t_rfc, t_rrd, t_wtr, t_rtp, t_faw, t_wr;

  spd_timing_decoder #(.CYC_W(CYC_W)) i_spd_timing_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .cfg_valid(cfg_valid), .cfg_err(cfg_err), .cas_lat(cas_lat), .t_rcd(t_rcd), .t_rp(t_rp),
    .t_ras(t_ras), .t_rc(t_rc), .t_rfc(t_rfc), .t_rrd(t_rrd), .t_wtr(t_wtr), .t_rtp(t_rtp),
    .t_faw(t_faw), .t_wr(t_wr));

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit run_done = 0;
  logic [7:0] img [64];

  // behavioural reference
  int m [30];
  bit m_pend, m_done;
  int e_valid, e_err;
  int e_cnt [11];

  function automatic int up(int n, int d);
    return (n + d - 1) / d;
  endfunction

  function automatic void model_finish();
    int tck, aa, pick, mask;
    bit fault;
    tck = m[12];
    mask = m[15] * 256 + m[14];
    fault = (m[2] != 11) || (m[3] != 2) || (m[10] == 0) || (m[11] == 0) || (tck == 0);
    pick = 0;
    if (!fault) begin
      aa = up(m[16], tck);
      for (int lat = 4; lat <= 19; lat++)
        if (pick == 0 && ((mask >> (lat - 4)) & 1) == 1 && lat >= aa) pick = lat;
      if (pick == 0) fault = 1;
    end
    if (fault) e_err = 1;
    else begin
      e_valid = 1;
      e_cnt[0]  = pick;
      e_cnt[1]  = up(m[18], tck);
      e_cnt[2]  = up(m[20], tck);
      e_cnt[3]  = up((m[21] % 16) * 256 + m[22], tck);
      e_cnt[4]  = up((m[21] / 16) * 256 + m[23], tck);
      e_cnt[5]  = up(m[25] * 256 + m[24], tck);
      e_cnt[6]  = up(m[19], tck);
      e_cnt[7]  = up(m[26], tck);
      e_cnt[8]  = up(m[27], tck);
      e_cnt[9]  = up((m[28] % 16) * 256 + m[29], tck);
      e_cnt[10] = up(m[17], tck);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 30; i++) m[i] = 0;
      m_pend = 0; m_done = 0; e_valid = 0; e_err = 0;
      for (int i = 0; i < 11; i++) e_cnt[i] = 0;
    end else if (m_pend) begin
      m_pend = 0; m_done = 1;
      model_finish();
    end else if (!m_done && in_valid) begin
      if (in_addr < 30) m[in_addr] = in_data;
      if (in_addr == 29) m_pend = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R9", "valid", int'(cfg_valid), e_valid);
    chk("R6", "err", int'(cfg_err), e_err);
    chk("R5", "cas_lat", int'(cas_lat), e_cnt[0]);
    chk("R3", "t_rcd", int'(t_rcd), e_cnt[1]);
    chk("R3", "t_rp", int'(t_rp), e_cnt[2]);
    chk("R4", "t_ras", int'(t_ras), e_cnt[3]);
    chk("R4", "t_rc", int'(t_rc), e_cnt[4]);
    chk("R4", "t_rfc", int'(t_rfc), e_cnt[5]);
    chk("R3", "t_rrd", int'(t_rrd), e_cnt[6]);
    chk("R3", "t_wtr", int'(t_wtr), e_cnt[7]);
    chk("R3", "t_rtp", int'(t_rtp), e_cnt[8]);
    chk("R4", "t_faw", int'(t_faw), e_cnt[9]);
    chk("R3", "t_wr", int'(t_wr), e_cnt[10]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !run_done) begin
      run_done = 1;
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic put(int a, int d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = 8'(a); in_data = 8'(d);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_addr = 8'd12; in_data = 8'hFF;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic base_image();
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    img[2] = 8'h0B; img[3] = 8'h02; img[10] = 8'h01; img[11] = 8'h08;
    img[12] = 8'h0A; img[14] = 8'hBC; img[15] = 8'h00; img[16] = 8'h69;
    img[17] = 8'h78; img[18] = 8'h69; img[19] = 8'h30; img[20] = 8'h69;
    img[21] = 8'h11; img[22] = 8'h18; img[23] = 8'h81; img[24] = 8'h70;
    img[25] = 8'h03; img[26] = 8'h3C; img[27] = 8'h3C; img[28] = 8'h00;
    img[29] = 8'hF0; img[30] = 8'h81; img[31] = 8'h77;
  endtask

  // streams bytes 0..40, with an invalid garbage cycle after byte 13 (R2),
  // then checks the result edge timing (R9)
  task automatic stream();
    for (int a = 0; a <= 29; a++) begin
      put(a, img[a]);
      if (a == 13) idle();
    end
    idle();
    @(negedge clk);
    chk("R9", "flags one edge after byte 29", int'(cfg_valid | cfg_err), 0);
    @(negedge clk);
    chk("R9", "flags two edges after byte 29", int'(cfg_valid | cfg_err), 1);
    for (int a = 30; a <= 40; a++) put(a, img[a]);
    idle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", "valid after reset", int'(cfg_valid), 0);
    chk("R1", "err after reset", int'(cfg_err), 0);
    chk("R1", "t_rfc after reset", int'(t_rfc), 0);

    // 1.25 ns module
    base_image();
    stream();
    chk("R5", "cl 1.25ns", int'(cas_lat), 11);
    chk("R3", "trcd 1.25ns", int'(t_rcd), 11);
    chk("R4", "tras 1.25ns", int'(t_ras), 28);
    chk("R4", "trc 1.25ns", int'(t_rc), 39);
    chk("R3", "trfc 1.25ns", int'(t_rfc), 88);
    chk("R4", "tfaw 1.25ns", int'(t_faw), 24);
    chk("R3", "trrd 1.25ns", int'(t_rrd), 5);
    chk("R3", "twr 1.25ns", int'(t_wr), 12);
    chk("R2", "garbage cycle ignored, valid", int'(cfg_valid), 1);

    // R10: more traffic after the result
    put(12, 8'h01); put(2, 8'h00); put(29, 8'h11); idle();
    repeat (3) @(negedge clk);
    chk("R10", "cl held", int'(cas_lat), 11);
    chk("R10", "trfc held", int'(t_rfc), 88);
    chk("R11", "err stays low", int'(cfg_err), 0);

    // 1.875 ns module, garbage in byte 28 upper nibble
    do_reset();
    base_image();
    img[12] = 8'h0F; img[14] = 8'h1C; img[22] = 8'h2C; img[23] = 8'h95;
    img[28] = 8'hA1; img[29] = 8'h2C;
    stream();
    chk("R5", "cl 1.875ns", int'(cas_lat), 7);
    chk("R4", "tras 1.875ns", int'(t_ras), 20);
    chk("R4", "trc 1.875ns", int'(t_rc), 27);
    chk("R3", "trfc 1.875ns", int'(t_rfc), 59);
    chk("R3", "trrd 1.875ns", int'(t_rrd), 4);
    chk("R4", "tfaw upper nibble of byte 28 ignored", int'(t_faw), 20);

    // R6 bad device key
    do_reset(); base_image(); img[2] = 8'h0C; stream();
    chk("R6", "device key err", int'(cfg_err), 1);
    chk("R6", "device key valid", int'(cfg_valid), 0);

    // R6 bad module key
    do_reset(); base_image(); img[3] = 8'h01; stream();
    chk("R6", "module key err", int'(cfg_err), 1);

    // R7 no latency reaches tAA
    do_reset(); base_image(); img[14] = 8'h01; stream();
    chk("R7", "no cl err", int'(cfg_err), 1);
    chk("R7", "no cl counts zero", int'(t_rcd), 0);

    // R8 zero tCK, zero divisor
    do_reset(); base_image(); img[12] = 8'h00; stream();
    chk("R8", "zero tck err", int'(cfg_err), 1);
    do_reset(); base_image(); img[11] = 8'h00; stream();
    chk("R8", "zero divisor err", int'(cfg_err), 1);

    // R5 latency from the high mask byte
    do_reset(); base_image(); img[14] = 8'h00; img[15] = 8'h04; img[16] = 8'h80; stream();
    chk("R5", "cl from high mask byte", int'(cas_lat), 14);

    // R5 exact multiple picks the equal latency, not the one below
    do_reset(); base_image(); img[14] = 8'h60; img[16] = 8'h64; stream();
    chk("R5", "cl exact multiple", int'(cas_lat), 10);

    run_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule